// File: doc/BRIEF.md
# DMA Descriptor Command Decoder

This block sits between the descriptor fetch logic and the channel sequencer of a descriptor-driven DMA engine. When a descriptor has been read from memory, the fetch logic presents its command word, requested byte count and data address and pulses a load strobe. One clock later the decoder presents a registered result to the sequencer. That result holds the operation class, an end-of-transfer flag, the effective key, the transfer length and address after normalisation, and a kill request.

The decoder catches descriptors that the channel must not execute and raises the kill request for them. These are transfers with a zero data address, transfers aimed at a key the channel does not serve, single-word register moves with an unsupported key, and unknown opcodes. For single-word moves it also folds the requested count into an aligned access of 1, 2 or 4 bytes. The register holds the decoded result until the next load strobe.

Top module: `dma_desc_decoder`

## Requirements
- R1: After reset `dec_valid` is 0 and every decoded output is 0. `dec_valid` is 1 in exactly the cycle after a cycle with `desc_load` high. Decoded outputs change only in the cycle after a load.
- R2: The opcode is `cmd_word[15:12]` and the key is `cmd_word[10:8]`. Opcodes 0/1 give class 0 (memory-to-stream), 2/3 give class 1 (stream-to-memory), 4 gives class 2 (word store), 5 gives class 3 (word load), 6 gives class 4 (no-op) and 7 gives class 5 (halt).
- R3: Opcodes 6 and 7 never raise kill, whatever the key, count or address.
- R4: For opcodes 0 to 5, key 4 raises kill.
- R5: For opcodes 0 to 3, kill is raised when the data address is zero or the key is above 3.
- R6: For opcodes 4 and 5, keys 0 to 3 are reported as key 6 (system memory) without kill. Keys 5 and 7 raise kill. Key 6 passes.
- R7: For opcodes 4 and 5, only `req_count[2:0]` counts. If bit 2 is set the length is 4 and address bits 1:0 are cleared. Otherwise, if bit 1 is set, the length is 2 and address bit 0 is cleared. Otherwise the length is 1 and the address is unchanged.
- R8: For opcodes 0 to 3, 6, 7 and 8 to 15, the length equals `req_count` and the address equals `data_addr`, unchanged.
- R9: Opcodes 8 to 15 give class 7 (illegal) and raise kill.
- R10: `last_seg` is 1 only for opcodes 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Descriptor fields valid this cycle; capture the decode |
| cmd_word | input | 16 | Descriptor command word |
| req_count | input | 16 | Requested byte count |
| data_addr | input | 32 | Descriptor data address |
| dec_valid | output | 1 | One-cycle strobe: decoded result is fresh |
| op_class | output | 3 | Operation class code (see R2, R9) |
| last_seg | output | 1 | End-of-transfer variant |
| key_out | output | 3 | Effective key after substitution |
| xfer_len | output | 16 | Normalised transfer length |
| xfer_addr | output | 32 | Normalised transfer address |
| kill | output | 1 | Channel kill request |

## Verification
Two functions can act on the same descriptor: key substitution and kill. A word move with key 5 or 7 is not substituted but is killed, while a key below 4 is substituted and passes. Likewise, a transfer can carry a zero address and an illegal key at once. The vector table provokes each of these overlaps and checks the class, key and kill fields together in the strobe cycle. A second overlap is a load in the same cycle as the previous result is still showing. Back-to-back loads with different descriptors check that each strobe cycle carries the new decode and never a mix of the two.

// File: rtl/dma_dec_pkg.sv
package dma_dec_pkg;

  typedef enum logic [2:0] {
    OPC_TX    = 3'd0,
    OPC_RX    = 3'd1,
    OPC_STORE = 3'd2,
    OPC_LOAD  = 3'd3,
    OPC_NOP   = 3'd4,
    OPC_HALT  = 3'd5,
    OPC_BAD   = 3'd7
  } op_class_e;

  localparam int OPC_HI  = 15;
  localparam int OPC_LO  = 12;
  localparam int KEY_HI  = 10;
  localparam int KEY_LO  = 8;
  localparam int KEY_W   = KEY_HI - KEY_LO + 1;

  localparam logic [KEY_W-1:0] KEY_BANNED = 3'd4;
  localparam logic [KEY_W-1:0] KEY_SYSMEM = 3'd6;

  // Byte count of a single-word move, from the low count bits.
  function automatic logic [2:0] word_bytes(input logic [2:0] cnt);
    if (cnt[2])      return 3'd4;
    else if (cnt[1]) return 3'd2;
    else             return 3'd1;
  endfunction

  // Address low bits that must be forced to zero for that size.
  function automatic logic [1:0] word_clear(input logic [2:0] cnt);
    if (cnt[2])      return 2'b11;
    else if (cnt[1]) return 2'b01;
    else             return 2'b00;
  endfunction

endpackage

// File: rtl/dma_dec_class.sv
module dma_dec_class
  import dma_dec_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             addr_zero,
  output logic [2:0]       op_class,
  output logic             last_seg,
  output logic [KEY_W-1:0] key_eff,
  output logic             is_word,
  output logic             kill
);

  localparam int OPC_W = OPC_HI - OPC_LO + 1;

  logic [OPC_W-1:0] opc;
  logic [KEY_W-1:0] key_raw;
  logic             key_banned;
  logic             stream_key_bad;
  logic             word_key_bad;

  assign opc            = cmd_word[OPC_HI:OPC_LO];
  assign key_raw        = cmd_word[KEY_HI:KEY_LO];
  assign key_banned     = (key_raw == KEY_BANNED);
  assign stream_key_bad = key_raw[KEY_W-1];
  assign word_key_bad   = key_raw[KEY_W-1] && (key_raw != KEY_SYSMEM);

  always_comb begin
    op_class = OPC_BAD;
    last_seg = 1'b0;
    key_eff  = key_raw;
    is_word  = 1'b0;
    kill     = 1'b0;
    if (opc[OPC_W-1]) begin
      op_class = OPC_BAD;
      kill     = 1'b1;
    end else begin
      case (opc[2:0])
        3'd0, 3'd1: begin
          op_class = OPC_TX;
          last_seg = opc[0];
          kill     = stream_key_bad || addr_zero;
        end
        3'd2, 3'd3: begin
          op_class = OPC_RX;
          last_seg = opc[0];
          kill     = stream_key_bad || addr_zero;
        end
        3'd4, 3'd5: begin
          op_class = opc[0] ? OPC_LOAD : OPC_STORE;
          is_word  = 1'b1;
          if (!key_raw[KEY_W-1]) key_eff = KEY_SYSMEM;
          kill     = key_banned || word_key_bad;
        end
        3'd6:    op_class = OPC_NOP;
        default: op_class = OPC_HALT;
      endcase
    end
  end

endmodule

// File: rtl/dma_dec_size.sv
module dma_dec_size
  import dma_dec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              is_word,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [ADDR_W-1:0] data_addr,
  output logic [CNT_W-1:0]  len,
  output logic [ADDR_W-1:0] addr
);

  logic [2:0] wbytes;
  logic [1:0] wclr;

  assign wbytes = word_bytes(req_count[2:0]);
  assign wclr   = word_clear(req_count[2:0]);

  always_comb begin
    if (is_word) begin
      len  = {{(CNT_W-3){1'b0}}, wbytes};
      addr = data_addr & ~{{(ADDR_W-2){1'b0}}, wclr};
    end else begin
      len  = req_count;
      addr = data_addr;
    end
  end

endmodule

// File: rtl/dma_dec_pipe.sv
module dma_dec_pipe #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/dma_desc_decoder.sv
module dma_desc_decoder
  import dma_dec_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_load,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [ADDR_W-1:0] data_addr,
  output logic              dec_valid,
  output logic [2:0]        op_class,
  output logic              last_seg,
  output logic [KEY_W-1:0]  key_out,
  output logic [CNT_W-1:0]  xfer_len,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              kill
);

  localparam int PW = 3 + 1 + KEY_W + CNT_W + ADDR_W + 1;

  // Named internal events, observed by the checker.
  logic              addr_zero;
  logic [2:0]        d_class;
  logic              d_last;
  logic [KEY_W-1:0]  d_key;
  logic              d_word;
  logic              d_kill;
  logic [CNT_W-1:0]  d_len;
  logic [ADDR_W-1:0] d_addr;
  logic [PW-1:0]     pipe_d;
  logic [PW-1:0]     pipe_q;

  assign addr_zero = (data_addr == '0);

  dma_dec_class #(.CMD_W(CMD_W)) u_class (
    .cmd_word (cmd_word),
    .addr_zero(addr_zero),
    .op_class (d_class),
    .last_seg (d_last),
    .key_eff  (d_key),
    .is_word  (d_word),
    .kill     (d_kill)
  );

  dma_dec_size #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_size (
    .is_word  (d_word),
    .req_count(req_count),
    .data_addr(data_addr),
    .len      (d_len),
    .addr     (d_addr)
  );

  assign pipe_d = {d_class, d_last, d_key, d_len, d_addr, d_kill};

  dma_dec_pipe #(.W(PW)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .load (desc_load),
    .d    (pipe_d),
    .q    (pipe_q),
    .valid(dec_valid)
  );

  assign {op_class, last_seg, key_out, xfer_len, xfer_addr, kill} = pipe_q;

endmodule

// File: rtl/dma_dec_checker.sv
module dma_dec_checker #(
  parameter int CMD_W  = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_load,
  input logic [CMD_W-1:0]  cmd_word,
  input logic [CNT_W-1:0]  req_count,
  input logic [ADDR_W-1:0] data_addr,
  input logic              dec_valid,
  input logic [2:0]        op_class,
  input logic              last_seg,
  input logic [2:0]        key_out,
  input logic [CNT_W-1:0]  xfer_len,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              kill,
  input logic              d_word
);

  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load |=> dec_valid); // R1

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_load |=> !dec_valid); // R1

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !desc_load |=> $stable({op_class, last_seg, key_out, xfer_len, xfer_addr, kill})); // R1

  AST_CTRL_NEVER_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load && (cmd_word[15:13] == 3'b011) |=> !kill); // R3

  AST_ZERO_ADDR_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load && (cmd_word[15:14] == 2'b00) && (data_addr == '0) |=> kill); // R5

  AST_WORD_KEY_SYSMEM: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (op_class == 3'd2 || op_class == 3'd3) && !kill |-> key_out == 3'd6); // R6

  AST_WORD_LEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load && d_word |=> ($countones(xfer_len) == 1) && (xfer_len <= 4)); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (op_class == 3'd2 || op_class == 3'd3) && xfer_len == 4 |-> xfer_addr[1:0] == 2'b00); // R7

  AST_BAD_OPC_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load && cmd_word[15] |=> kill && op_class == 3'd7); // R9

  AST_LAST_ONLY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && last_seg |-> op_class <= 3'd1); // R10

endmodule

bind dma_desc_decoder dma_dec_checker #(
  .CMD_W(CMD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_dec_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .desc_load(desc_load),
  .cmd_word (cmd_word),
  .req_count(req_count),
  .data_addr(data_addr),
  .dec_valid(dec_valid),
  .op_class (op_class),
  .last_seg (last_seg),
  .key_out  (key_out),
  .xfer_len (xfer_len),
  .xfer_addr(xfer_addr),
  .kill     (kill),
  .d_word   (d_word)
);

// File: tb/test_dma_desc_decoder.sv
module test_dma_desc_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 20;
  localparam int VW         = 124;

  function automatic logic [VW-1:0] mkv(
    input logic [3:0] req, input logic [15:0] cmd, input logic [15:0] cnt,
    input logic [31:0] addr, input logic [2:0] op, input logic last,
    input logic [2:0] key, input logic kl, input logic [15:0] len,
    input logic [31:0] ea);
    return {req, cmd, cnt, addr, op, last, key, kl, len, ea};
  endfunction

  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(4'd2,  16'h0000, 16'h0100, 32'h0000_1000, 3'd0, 1'b0, 3'd0, 1'b0, 16'h0100, 32'h0000_1000), // R2 R8
    mkv(4'd10, 16'h1200, 16'h0040, 32'h0000_2000, 3'd0, 1'b1, 3'd2, 1'b0, 16'h0040, 32'h0000_2000), // R10
    mkv(4'd2,  16'h2300, 16'h0010, 32'h0000_3004, 3'd1, 1'b0, 3'd3, 1'b0, 16'h0010, 32'h0000_3004), // R2
    mkv(4'd10, 16'h3100, 16'h0008, 32'h0000_0004, 3'd1, 1'b1, 3'd1, 1'b0, 16'h0008, 32'h0000_0004), // R10
    mkv(4'd5,  16'h0000, 16'h0005, 32'h0000_0000, 3'd0, 1'b0, 3'd0, 1'b1, 16'h0005, 32'h0000_0000), // R5 zero addr
    mkv(4'd5,  16'h1500, 16'h0001, 32'h0000_0100, 3'd0, 1'b1, 3'd5, 1'b1, 16'h0001, 32'h0000_0100), // R5 key 5
    mkv(4'd4,  16'h2400, 16'h0003, 32'h0000_0200, 3'd1, 1'b0, 3'd4, 1'b1, 16'h0003, 32'h0000_0200), // R4
    mkv(4'd7,  16'h4600, 16'h0007, 32'h0000_1237, 3'd2, 1'b0, 3'd6, 1'b0, 16'h0004, 32'h0000_1234), // R7 len 4
    mkv(4'd6,  16'h5000, 16'h0002, 32'h0000_0003, 3'd3, 1'b0, 3'd6, 1'b0, 16'h0002, 32'h0000_0002), // R6 R7 len 2
    mkv(4'd6,  16'h5300, 16'h0001, 32'h0000_0007, 3'd3, 1'b0, 3'd6, 1'b0, 16'h0001, 32'h0000_0007), // R6 R7 len 1
    mkv(4'd6,  16'h4500, 16'hFFF8, 32'h0000_0009, 3'd2, 1'b0, 3'd5, 1'b1, 16'h0001, 32'h0000_0009), // R6 key 5
    mkv(4'd6,  16'h5700, 16'h0006, 32'h0000_000B, 3'd3, 1'b0, 3'd7, 1'b1, 16'h0004, 32'h0000_0008), // R6 key 7
    mkv(4'd4,  16'h4400, 16'h0002, 32'h0000_0005, 3'd2, 1'b0, 3'd4, 1'b1, 16'h0002, 32'h0000_0004), // R4 word
    mkv(4'd3,  16'h6400, 16'h1234, 32'h0000_0000, 3'd4, 1'b0, 3'd4, 1'b0, 16'h1234, 32'h0000_0000), // R3 R8
    mkv(4'd3,  16'h7F3F, 16'h0000, 32'hDEAD_BEEF, 3'd5, 1'b0, 3'd7, 1'b0, 16'h0000, 32'hDEAD_BEEF), // R3
    mkv(4'd9,  16'h8000, 16'h0077, 32'h0000_0010, 3'd7, 1'b0, 3'd0, 1'b1, 16'h0077, 32'h0000_0010), // R9
    mkv(4'd9,  16'hF123, 16'h0004, 32'h0000_0000, 3'd7, 1'b0, 3'd1, 1'b1, 16'h0004, 32'h0000_0000), // R9
    mkv(4'd9,  16'h9600, 16'h0005, 32'h0000_0013, 3'd7, 1'b0, 3'd6, 1'b1, 16'h0005, 32'h0000_0013), // R9 R10
    mkv(4'd5,  16'h103F, 16'h0020, 32'h0000_0000, 3'd0, 1'b1, 3'd0, 1'b1, 16'h0020, 32'h0000_0000), // R5
    mkv(4'd5,  16'h3400, 16'h0020, 32'h0000_0000, 3'd1, 1'b1, 3'd4, 1'b1, 16'h0020, 32'h0000_0000)  // R5 R4 overlap
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_load = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [15:0] req_count = '0;
  logic [31:0] data_addr = '0;
  logic        dec_valid;
  logic [2:0]  op_class;
  logic        last_seg;
  logic [2:0]  key_out;
  logic [15:0] xfer_len;
  logic [31:0] xfer_addr;
  logic        kill;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_desc_decoder i_dma_desc_decoder (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .cmd_word(cmd_word),
    .req_count(req_count), .data_addr(data_addr), .dec_valid(dec_valid),
    .op_class(op_class), .last_seg(last_seg), .key_out(key_out),
    .xfer_len(xfer_len), .xfer_addr(xfer_addr), .kill(kill)
  );

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] c, input logic [15:0] n, input logic [31:0] a);
    @(negedge clk);
    cmd_word  = c;
    req_count = n;
    data_addr = a;
    desc_load = 1'b1;
  endtask

  task automatic check_vec(input logic [VW-1:0] v);
    int r;
    r = int'(v[123:120]);
    chk(r, "valid", {31'd0, dec_valid}, 32'd1);
    chk(r, "class", {29'd0, op_class},  {29'd0, v[55:53]});
    chk(r, "last",  {31'd0, last_seg},  {31'd0, v[52]});
    chk(r, "key",   {29'd0, key_out},   {29'd0, v[51:49]});
    chk(r, "kill",  {31'd0, kill},      {31'd0, v[48]});
    chk(r, "len",   {16'd0, xfer_len},  {16'd0, v[47:32]});
    chk(r, "addr",  xfer_addr,          v[31:0]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    chk(1, "reset valid", {31'd0, dec_valid}, 32'd0);
    chk(1, "reset class", {29'd0, op_class}, 32'd0);
    chk(1, "reset kill",  {31'd0, kill}, 32'd0);
    chk(1, "reset len",   {16'd0, xfer_len}, 32'd0);
    chk(1, "reset addr",  xfer_addr, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: one load, check in the following cycle.
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][119:104], VEC[i][103:88], VEC[i][87:56]);
      @(negedge clk);
      desc_load = 1'b0;
      check_vec(VEC[i]);
    end

    // R1: strobe drops and result holds while inputs change without a load.
    drive(16'h4600, 16'h0004, 32'h0000_00FF);  // R7 expect len 4 addr FC
    @(negedge clk);
    desc_load = 1'b0;
    cmd_word  = 16'h8000;
    req_count = 16'h0001;
    data_addr = 32'h0;
    @(negedge clk);
    chk(1, "valid drops", {31'd0, dec_valid}, 32'd0);
    chk(1, "hold class",  {29'd0, op_class}, 32'd2);
    chk(1, "hold kill",   {31'd0, kill}, 32'd0);
    chk(7, "hold len",    {16'd0, xfer_len}, 32'd4);
    chk(7, "hold addr",   xfer_addr, 32'h0000_00FC);

    // Back-to-back loads: each strobe cycle shows its own descriptor.
    drive(16'h0000, 16'h0000, 32'h0000_0000);  // R5 killed
    @(negedge clk);
    cmd_word  = 16'h6000;                      // R3 no-op, load stays high
    req_count = 16'h0009;
    data_addr = 32'h0000_0000;
    chk(5, "b2b first kill", {31'd0, kill}, 32'd1);
    chk(1, "b2b first valid", {31'd0, dec_valid}, 32'd1);
    @(negedge clk);
    desc_load = 1'b0;
    chk(3, "b2b second kill", {31'd0, kill}, 32'd0);
    chk(2, "b2b second class", {29'd0, op_class}, 32'd4);
    chk(8, "b2b second len", {16'd0, xfer_len}, 32'd9);
    chk(1, "b2b second valid", {31'd0, dec_valid}, 32'd1);
    @(negedge clk);
    chk(1, "b2b strobe ends", {31'd0, dec_valid}, 32'd0);

    // R1: reset mid-stream clears the register.
    rst_n = 1'b0;
    #1;
    chk(1, "async reset class", {29'd0, op_class}, 32'd0);
    chk(1, "async reset len",   {16'd0, xfer_len}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule